// File: doc/BRIEF.md
# Row Tag Lookup Buffer for a DRAM Cache

This block sits in the memory controller in front of a DRAM cache whose block tags are kept inside each DRAM row, next to the blocks they describe. Each DRAM cache row holds `BLKS` blocks of `BLK_BYTES` bytes, and the tag of every block sits in a small metadata area of that same row. Reading DRAM just to learn hit or miss would cost a second DRAM access for every load. To avoid this, a small direct-mapped on-chip buffer keeps the complete tag groups of recently used DRAM rows.

A load address enters on the request port. If the buffer holds the tag group for that address's row, the block's hit or miss in the DRAM cache is decided at once and a single data access command is issued. If the buffer does not hold it, the block first issues a metadata read for the row. It waits for the tag group on the fill port, installs the group in the buffer, and decides hit or miss from the returned tags. It then issues the data access, which lands in the row just opened. The hit or miss result leaves on the response port.

Only one request is in flight at a time. When the DRAM cache writes a new block into a row, the install pins update the buffered tags of that row in the same cycle. This keeps the buffer consistent with the tags in DRAM.

Top module: `tag_row_buffer`

## Requirements
- R1: The load address is split as follows, with the default parameters. Bits [6:0] are the byte offset and are ignored. Bits [8:7] select the block slot in the row. Bits [16:9] are the DRAM cache row. Bits [31:17] are the block tag. The buffer index is the low 6 bits of the row; the upper 2 row bits are kept in the entry as its row tag. Every command carries the row and slot of the request being served.
- R2: `req_ready` is high only when no request is in flight. It goes low on the cycle after a request is accepted and stays low through any metadata fetch, until the response has been taken.
- R3: On a buffer hit, exactly one command is issued: a data access (`cmd_meta`=0). The response follows once that command is accepted.
- R4: On a buffer miss, the first command is a metadata read (`cmd_meta`=1). Once it is accepted, `fill_ready` rises. After a fill beat is taken, the next command is the data access, and after that the response.
- R5: A row whose tag group has been filled stays resident. A later request to any slot of that row issues no metadata read.
- R6: The response reports a DRAM cache hit (`rsp_hit`=1) exactly when the requested slot's valid bit is set and its stored tag equals the request's block tag. After a miss, this uses the fill data. After a buffer hit, it uses the buffered group as it stood before the accepting edge. In `fill_tags`, slot s occupies bits [s*TAG_W +: TAG_W]; in `fill_bv`, it occupies bit s.
- R7: The buffer is direct-mapped. Two rows sharing an index but differing in row tag evict each other, so a request to the evicted row fetches metadata again.
- R8: An `inst_valid` pulse whose row is resident sets that slot's tag and valid bit on the same edge. If the row is not resident, the pulse is ignored and creates no entry. A fill and an install to the same entry on one edge apply the fill first.
- R9: A command or response held back by its ready signal keeps its valid and fields stable. `fill_ready` is high only while metadata is awaited.
- R10: After reset the buffer is empty: the first request always fetches metadata. `req_ready` is high, and no command, response or fill handshake is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W (32) | Load byte address |
| cmd_valid | output | 1 | DRAM command offered |
| cmd_ready | input | 1 | DRAM side takes the command |
| cmd_meta | output | 1 | 1: metadata read of the row, 0: data access |
| cmd_row | output | ROW_W (8) | DRAM cache row of the command |
| cmd_slot | output | SLOT_W (2) | Block slot for a data access |
| fill_valid | input | 1 | Row tag group returned from DRAM |
| fill_ready | output | 1 | Block waits for a tag group |
| fill_tags | input | BLKS*TAG_W (60) | Block tags of the row, slot s at [s*TAG_W +: TAG_W] |
| fill_bv | input | BLKS (4) | Block valid bits of the row, slot s at bit s |
| inst_valid | input | 1 | DRAM cache wrote a block this cycle |
| inst_addr | input | ADDR_W (32) | Address of the written block |
| rsp_valid | output | 1 | Lookup result offered |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_hit | output | 1 | 1: block present in the DRAM cache |

## Verification
The assertions check on every cycle these handshake rules:
- the four handshake-facing signals never overlap, and `req_ready` drops after an accept;
- a stalled command or response holds steady;
- the order is metadata read, then waiting for a fill, then data access, then response;
- each command carries the row and slot of the accepted request.

Some behaviours depend on the history of the buffer, and only the bench scenarios, compared each cycle against a behavioural model, can show them:
- whether a row is resident or has been evicted by a conflicting row;
- whether an install landed or was dropped;
- whether the reported hit matches the stored tags.

// File: rtl/tag_row_pkg.sv
package tag_row_pkg;

  // Sequencer phases of one in-flight lookup.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_META = 3'd1,
    PH_FILL = 3'd2,
    PH_DATA = 3'd3,
    PH_RESP = 3'd4
  } trb_phase_e;

endpackage

// File: rtl/trb_store.sv
module trb_store #(
  parameter int ENTRIES = 64,
  parameter int BLKS    = 4,
  parameter int TAG_W   = 15,
  parameter int RTAG_W  = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int SLOT_W = $clog2(BLKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  // lookup read port
  input  logic [IDX_W-1:0]      rd_idx,
  output logic                  rd_live,
  output logic [RTAG_W-1:0]     rd_rtag,
  output logic [BLKS*TAG_W-1:0] rd_tags,
  output logic [BLKS-1:0]       rd_bv,
  // whole-group install after a metadata fetch
  input  logic                  fill_we,
  input  logic [IDX_W-1:0]      fill_idx,
  input  logic [RTAG_W-1:0]     fill_rtag,
  input  logic [BLKS*TAG_W-1:0] fill_tags,
  input  logic [BLKS-1:0]       fill_bv,
  // single-block update when the DRAM cache writes a block
  input  logic                  upd_we,
  input  logic [IDX_W-1:0]      upd_idx,
  input  logic [RTAG_W-1:0]     upd_rtag,
  input  logic [SLOT_W-1:0]     upd_slot,
  input  logic [TAG_W-1:0]      upd_tag
);

  logic [ENTRIES-1:0]    live;
  logic [RTAG_W-1:0]     rtag_mem [ENTRIES];
  logic [BLKS*TAG_W-1:0] tag_mem  [ENTRIES];
  logic [BLKS-1:0]       bv_mem   [ENTRIES];
  logic                  upd_match;

  // The update only lands if its row is resident once this edge's fill is applied.
  always_comb begin
    if (fill_we && (fill_idx == upd_idx))
      upd_match = upd_we && (fill_rtag == upd_rtag);
    else
      upd_match = upd_we && live[upd_idx] && (rtag_mem[upd_idx] == upd_rtag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      live <= '0;
    else if (fill_we)
      live[fill_idx] <= 1'b1;
  end

  // Fill first, then the block update overrides its own slot.
  always_ff @(posedge clk) begin
    if (fill_we) begin
      rtag_mem[fill_idx] <= fill_rtag;
      tag_mem[fill_idx]  <= fill_tags;
      bv_mem[fill_idx]   <= fill_bv;
    end
    if (upd_match) begin
      tag_mem[upd_idx][int'(upd_slot)*TAG_W +: TAG_W] <= upd_tag;
      bv_mem[upd_idx][upd_slot]                      <= 1'b1;
    end
  end

  assign rd_live = live[rd_idx];
  assign rd_rtag = rtag_mem[rd_idx];
  assign rd_tags = tag_mem[rd_idx];
  assign rd_bv   = bv_mem[rd_idx];

endmodule

// File: rtl/trb_ctrl.sv
module trb_ctrl
  import tag_row_pkg::*;
#(
  parameter int BLKS   = 4,
  parameter int TAG_W  = 15,
  parameter int ROW_W  = 8,
  parameter int IDX_W  = 6,
  localparam int SLOT_W = $clog2(BLKS),
  localparam int RTAG_W = ROW_W - IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [TAG_W-1:0]      req_tag,
  input  logic [ROW_W-1:0]      req_row,
  input  logic [SLOT_W-1:0]     req_slot,
  input  logic                  buf_live,
  input  logic [RTAG_W-1:0]     buf_rtag,
  input  logic [BLKS*TAG_W-1:0] buf_tags,
  input  logic [BLKS-1:0]       buf_bv,
  output logic                  cmd_valid,
  input  logic                  cmd_ready,
  output logic                  cmd_meta,
  output logic [ROW_W-1:0]      cmd_row,
  output logic [SLOT_W-1:0]     cmd_slot,
  input  logic                  fill_valid,
  output logic                  fill_ready,
  input  logic [BLKS*TAG_W-1:0] fill_tags,
  input  logic [BLKS-1:0]       fill_bv,
  output logic                  fill_we,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_hit
);

  trb_phase_e          ph;
  logic [ROW_W-1:0]    row_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [TAG_W-1:0]    tag_q;
  logic                hit_q;
  logic                row_resident;
  logic                blk_hit_buf;
  logic                blk_hit_fill;

  assign row_resident = buf_live && (buf_rtag == req_row[ROW_W-1:IDX_W]);
  assign blk_hit_buf  = buf_bv[req_slot] &&
                        (buf_tags[int'(req_slot)*TAG_W +: TAG_W] == req_tag);
  assign blk_hit_fill = fill_bv[slot_q] &&
                        (fill_tags[int'(slot_q)*TAG_W +: TAG_W] == tag_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      row_q  <= '0;
      slot_q <= '0;
      tag_q  <= '0;
      hit_q  <= 1'b0;
    end else begin
      unique case (ph)
        PH_IDLE: if (req_valid) begin
          row_q  <= req_row;
          slot_q <= req_slot;
          tag_q  <= req_tag;
          if (row_resident) begin
            hit_q <= blk_hit_buf;
            ph    <= PH_DATA;
          end else begin
            ph <= PH_META;
          end
        end
        PH_META: if (cmd_ready) ph <= PH_FILL;
        PH_FILL: if (fill_valid) begin
          hit_q <= blk_hit_fill;
          ph    <= PH_DATA;
        end
        PH_DATA: if (cmd_ready) ph <= PH_RESP;
        PH_RESP: if (rsp_ready) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign req_ready  = (ph == PH_IDLE);
  assign cmd_valid  = (ph == PH_META) || (ph == PH_DATA);
  assign cmd_meta   = (ph == PH_META);
  assign cmd_row    = row_q;
  assign cmd_slot   = slot_q;
  assign fill_ready = (ph == PH_FILL);
  assign fill_we    = fill_ready && fill_valid;
  assign rsp_valid  = (ph == PH_RESP);
  assign rsp_hit    = hit_q;

endmodule

// File: rtl/tag_row_buffer.sv
module tag_row_buffer #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 128,
  parameter int BLKS      = 4,
  parameter int CROWS     = 256,
  parameter int ENTRIES   = 64,
  localparam int OFF_W  = $clog2(BLK_BYTES),
  localparam int SLOT_W = $clog2(BLKS),
  localparam int ROW_W  = $clog2(CROWS),
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int RTAG_W = ROW_W - IDX_W,
  localparam int TAG_W  = ADDR_W - OFF_W - SLOT_W - ROW_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  output logic                  cmd_valid,
  input  logic                  cmd_ready,
  output logic                  cmd_meta,
  output logic [ROW_W-1:0]      cmd_row,
  output logic [SLOT_W-1:0]     cmd_slot,
  input  logic                  fill_valid,
  output logic                  fill_ready,
  input  logic [BLKS*TAG_W-1:0] fill_tags,
  input  logic [BLKS-1:0]       fill_bv,
  input  logic                  inst_valid,
  input  logic [ADDR_W-1:0]     inst_addr,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_hit
);

  logic [SLOT_W-1:0]     rq_slot, in_slot;
  logic [ROW_W-1:0]      rq_row,  in_row;
  logic [TAG_W-1:0]      rq_tag,  in_tag;
  logic                  buf_live;
  logic [RTAG_W-1:0]     buf_rtag;
  logic [BLKS*TAG_W-1:0] buf_tags;
  logic [BLKS-1:0]       buf_bv;
  logic                  fill_we;
  logic                  unused_offsets;

  // Address fields: offset | slot | row | block tag, from LSB up.
  assign rq_slot = req_addr[OFF_W +: SLOT_W];
  assign rq_row  = req_addr[OFF_W+SLOT_W +: ROW_W];
  assign rq_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign in_slot = inst_addr[OFF_W +: SLOT_W];
  assign in_row  = inst_addr[OFF_W+SLOT_W +: ROW_W];
  assign in_tag  = inst_addr[ADDR_W-1 -: TAG_W];
  assign unused_offsets = ^{req_addr[OFF_W-1:0], inst_addr[OFF_W-1:0]};

  trb_store #(
    .ENTRIES(ENTRIES), .BLKS(BLKS), .TAG_W(TAG_W), .RTAG_W(RTAG_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (rq_row[IDX_W-1:0]),
    .rd_live  (buf_live),
    .rd_rtag  (buf_rtag),
    .rd_tags  (buf_tags),
    .rd_bv    (buf_bv),
    .fill_we  (fill_we),
    .fill_idx (cmd_row[IDX_W-1:0]),
    .fill_rtag(cmd_row[ROW_W-1:IDX_W]),
    .fill_tags(fill_tags),
    .fill_bv  (fill_bv),
    .upd_we   (inst_valid),
    .upd_idx  (in_row[IDX_W-1:0]),
    .upd_rtag (in_row[ROW_W-1:IDX_W]),
    .upd_slot (in_slot),
    .upd_tag  (in_tag)
  );

  trb_ctrl #(
    .BLKS(BLKS), .TAG_W(TAG_W), .ROW_W(ROW_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_tag   (rq_tag),
    .req_row   (rq_row),
    .req_slot  (rq_slot),
    .buf_live  (buf_live),
    .buf_rtag  (buf_rtag),
    .buf_tags  (buf_tags),
    .buf_bv    (buf_bv),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_meta  (cmd_meta),
    .cmd_row   (cmd_row),
    .cmd_slot  (cmd_slot),
    .fill_valid(fill_valid),
    .fill_ready(fill_ready),
    .fill_tags (fill_tags),
    .fill_bv   (fill_bv),
    .fill_we   (fill_we),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_hit   (rsp_hit)
  );

endmodule

// File: rtl/tag_row_buffer_chk.sv
module tag_row_buffer_chk #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 128,
  parameter int BLKS      = 4,
  parameter int CROWS     = 256,
  localparam int OFF_W  = $clog2(BLK_BYTES),
  localparam int SLOT_W = $clog2(BLKS),
  localparam int ROW_W  = $clog2(CROWS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_meta,
  input logic [ROW_W-1:0]  cmd_row,
  input logic [SLOT_W-1:0] cmd_slot,
  input logic              fill_valid,
  input logic              fill_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit
);

  logic unused_chk;
  assign unused_chk = ^{req_addr[ADDR_W-1:OFF_W+SLOT_W+ROW_W], req_addr[OFF_W-1:0]};

  // R2: only one handshake-facing signal may be offered at a time
  p_one_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, cmd_valid, fill_ready, rsp_valid}));

  // R2: accepting a request closes the request port
  p_accept_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R1: the first command carries the accepted request's row and slot
  p_cmd_fields_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd_valid &&
      cmd_row == $past(req_addr[OFF_W+SLOT_W +: ROW_W]) &&
      cmd_slot == $past(req_addr[OFF_W +: SLOT_W])));

  // R9: a stalled command holds
  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_meta) &&
      $stable(cmd_row) && $stable(cmd_slot)));

  // R9: a stalled response holds
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit)));

  // R4: a taken metadata read opens the fill port
  p_meta_then_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_meta) |=> fill_ready);

  // R4: a taken fill is followed by the data access
  p_fill_then_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=> (cmd_valid && !cmd_meta));

  // R3: a taken data access is followed by the response
  p_data_then_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_meta) |=> rsp_valid);

endmodule

bind tag_row_buffer tag_row_buffer_chk #(
  .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .BLKS(BLKS), .CROWS(CROWS)
) u_chk (.*);

// File: tb/tag_row_buffer_test.sv
`timescale 1ns/1ps
module tag_row_buffer_test;

  localparam int NB   = 4;   // blocks per row
  localparam int TW   = 15;  // block tag width
  localparam int NIDX = 64;  // buffer entries

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [31:0]   req_addr = '0;
  logic          cmd_ready = 1'b0;
  logic          fill_valid = 1'b0;
  logic [59:0]   fill_tags = '0;
  logic [3:0]    fill_bv = '0;
  logic          inst_valid = 1'b0;
  logic [31:0]   inst_addr = '0;
  logic          rsp_ready = 1'b0;
  logic          req_ready, cmd_valid, cmd_meta, fill_ready, rsp_valid, rsp_hit;
  logic [7:0]    cmd_row;
  logic [1:0]    cmd_slot;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int meta_cnt = 0;
  bit last_hit;
  int fill_row = 0;

  // backing store of row metadata as DRAM holds it
  int unsigned dtag[int];
  bit          dbv[int];

  // behavioural model
  int m_ph = 0;
  int m_row, m_slot;
  int unsigned m_tag;
  bit m_hit;
  int unsigned b_row[int];
  int unsigned b_tag[int];
  bit          b_bv[int];

  always #10 clk = ~clk;

  tag_row_buffer uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_meta(cmd_meta),
    .cmd_row(cmd_row), .cmd_slot(cmd_slot),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_tags(fill_tags), .fill_bv(fill_bv),
    .inst_valid(inst_valid), .inst_addr(inst_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit)
  );

  function automatic logic [31:0] mk(int unsigned tag, int row, int slot);
    return {tag[14:0], row[7:0], slot[1:0], 7'd0};
  endfunction

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Reference model: advances on each edge from the bench-driven inputs.
  always @(posedge clk) begin
    int r, s, i;
    int unsigned t;
    if (!rst_n) begin
      m_ph = 0;
      b_row.delete(); b_tag.delete(); b_bv.delete();
    end else begin
      case (m_ph)
        0: if (req_valid) begin
          s = int'(req_addr[8:7]); r = int'(req_addr[16:9]); t = req_addr[31:17];
          m_row = r; m_slot = s; m_tag = t;
          i = r % NIDX;
          if (b_row.exists(i) && b_row[i] == r) begin
            m_hit = b_bv[i*NB+s] && (b_tag[i*NB+s] == t);
            m_ph = 3;
          end else m_ph = 1;
        end
        1: if (cmd_ready) m_ph = 2;
        2: if (fill_valid) begin
          i = m_row % NIDX;
          b_row[i] = m_row;
          for (int k = 0; k < NB; k++) begin
            b_tag[i*NB+k] = fill_tags[k*TW +: TW];
            b_bv[i*NB+k]  = fill_bv[k];
          end
          m_hit = fill_bv[m_slot] && (fill_tags[m_slot*TW +: TW] == m_tag);
          m_ph = 3;
        end
        3: if (cmd_ready) m_ph = 4;
        4: if (rsp_ready) m_ph = 0;
        default: m_ph = 0;
      endcase
      if (inst_valid) begin
        s = int'(inst_addr[8:7]); r = int'(inst_addr[16:9]); t = inst_addr[31:17];
        i = r % NIDX;
        if (b_row.exists(i) && b_row[i] == r) begin
          b_tag[i*NB+s] = t;
          b_bv[i*NB+s]  = 1'b1;
        end
      end
    end
  end

  // Per-cycle comparison, then the DRAM-side environment drives its inputs.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready == (m_ph == 0), "R2 req_ready", req_ready, m_ph == 0);
      chk(cmd_valid == (m_ph == 1 || m_ph == 3), "R4 cmd_valid", cmd_valid,
          m_ph == 1 || m_ph == 3);
      if (m_ph == 1 || m_ph == 3) begin
        chk(cmd_meta == (m_ph == 1), "R3 cmd_meta", cmd_meta, m_ph == 1);
        chk(cmd_row == m_row, "R1 cmd_row", cmd_row, m_row);
        chk(cmd_slot == m_slot, "R1 cmd_slot", cmd_slot, m_slot);
      end
      chk(fill_ready == (m_ph == 2), "R9 fill_ready", fill_ready, m_ph == 2);
      chk(rsp_valid == (m_ph == 4), "R3 rsp_valid", rsp_valid, m_ph == 4);
      if (m_ph == 4) chk(rsp_hit == m_hit, "R6 rsp_hit", rsp_hit, m_hit);

      cmd_ready = ($urandom % 4) != 0;
      if (cmd_valid && cmd_meta) fill_row = int'(cmd_row);
      if (cmd_valid && cmd_meta && cmd_ready) meta_cnt++;
      for (int k = 0; k < NB; k++) begin
        fill_tags[k*TW +: TW] = dtag.exists(fill_row*NB+k) ? dtag[fill_row*NB+k][14:0] : '0;
        fill_bv[k] = dbv.exists(fill_row*NB+k) ? dbv[fill_row*NB+k] : 1'b0;
      end
      fill_valid = fill_ready && (($urandom % 3) != 0);
      rsp_ready = ($urandom % 3) != 0;
      if (rsp_valid && rsp_ready) last_hit = rsp_hit;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R2 watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic issue(logic [31:0] a);
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic install(int unsigned tag, int row, int slot);
    dtag[row*NB+slot] = tag;
    dbv[row*NB+slot]  = 1'b1;
    inst_valid = 1'b1;
    inst_addr  = mk(tag, row, slot);
    @(negedge clk);
    inst_valid = 1'b0;
  endtask

  task automatic lookup(logic [31:0] a, int exp_meta, bit exp_hit, string rq);
    int m0;
    m0 = meta_cnt;
    issue(a);
    wait_idle();
    chk(meta_cnt - m0 == exp_meta, {rq, " metadata reads"}, meta_cnt - m0, exp_meta);
    chk(last_hit == exp_hit, {rq, " hit"}, last_hit, exp_hit);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: state right after reset
    chk(req_ready == 1'b1, "R10 req_ready", req_ready, 1);
    chk(cmd_valid == 1'b0, "R10 cmd_valid", cmd_valid, 0);
    chk(rsp_valid == 1'b0, "R10 rsp_valid", rsp_valid, 0);
    chk(fill_ready == 1'b0, "R10 fill_ready", fill_ready, 0);

    lookup(mk(5, 3, 1), 1, 0, "R10 empty buffer");
    @(negedge clk);
    install(5, 3, 1);
    lookup(mk(5, 3, 1), 0, 1, "R8 resident install");
    lookup(mk(6, 3, 1), 0, 0, "R5 tag mismatch");
    lookup(mk(5, 3, 2), 0, 0, "R6 invalid slot");
    lookup(mk(5, 67, 1), 1, 0, "R7 conflict row");
    lookup(mk(5, 3, 1), 1, 1, "R7 evicted row");
    @(negedge clk);
    install(9, 10, 0);
    lookup(mk(9, 10, 0), 1, 1, "R8 non-resident install ignored");
    lookup(mk(9, 10, 0), 0, 1, "R5 refilled row");
    lookup(mk(4, 10, 3), 0, 0, "R5 other slot");

    // mixed traffic, checked cycle by cycle against the model
    for (int n = 0; n < 400; n++) begin
      int rows[6] = '{0, 1, 64, 65, 128, 2};
      if (($urandom % 4) == 0)
        install($urandom % 4, rows[$urandom % 6], $urandom % 4);
      issue(mk($urandom % 4, rows[$urandom % 6], $urandom % 4));
      if (($urandom % 2) == 0) wait_idle();
    end
    wait_idle();
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule